// File: doc/BRIEF.md
# Barrel Shifter with Carry and Extend Flags

This block is a single-cycle, purely combinational shifter for a 32-bit integer datapath. It performs a logical left, a logical right or an arithmetic right shift of one operand. The shift distance is read from a register-width count input. Next to the shifted value it produces the condition flags that a processor's status logic consumes: carry, extend, negative, zero and overflow.

The caller supplies the carry flag as it stands before the shift. A shift whose effective distance is zero leaves that carry untouched. Only the low six bits of the count take part, so any register value can be used as the distance. Distances of exactly the word width, and distances beyond it, follow their own rules, so a wrapped or oversized count never produces an undefined result.

Top module: `shf_unit`

## Requirements
- R1: Only the low CNT_W (default 6) bits of `count_i` are used: a count of 68 behaves as 4, and a count of 64 behaves as 0.
- R2: With an effective count of 0, `result_o` equals `operand_i` and `c_o` equals `c_prev_i`, for every operation.
- R3: Left shift (`op_i` = 2'b00) by n in 1..31 gives `operand_i << n`, and `c_o` is operand bit 32-n.
- R4: Left shift by exactly 32 gives 0 with `c_o` = operand bit 0. Left shift by 33..63 gives 0 with `c_o` = 0.
- R5: Logical right shift (`op_i` = 2'b01) by n in 1..31 zero-fills from the top, and `c_o` is operand bit n-1.
- R6: Logical right shift by exactly 32 gives 0 with `c_o` = operand bit 31. Logical right shift by 33..63 gives 0 with `c_o` = 0.
- R7: Arithmetic right shift (`op_i` = 2'b10) by n in 1..31 fills with copies of bit 31, and `c_o` is operand bit n-1.
- R8: Arithmetic right shift by 32..63 gives 32 copies of operand bit 31, and `c_o` equals operand bit 31.
- R9: `x_o` equals `c_o` in every case, including a zero count and the pass-through code.
- R10: `n_o` is bit 31 of the result, `z_o` is 1 exactly when the result is all zeros, and `v_o` is always 0.
- R11: `op_i` = 2'b11 passes the operand through unchanged with `c_o` = `c_prev_i`, whatever the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_i | input | 32 | Value to be shifted |
| count_i | input | 32 | Shift distance; only the low 6 bits are used |
| op_i | input | 2 | 00 left, 01 logical right, 10 arithmetic right, 11 pass |
| c_prev_i | input | 1 | Carry flag before this operation |
| result_o | output | 32 | Shifted value |
| c_o | output | 1 | Carry out |
| x_o | output | 1 | Extend flag, a copy of the carry |
| n_o | output | 1 | Result bit 31 |
| z_o | output | 1 | Result is zero |
| v_o | output | 1 | Overflow, always cleared |

## Verification
The bench builds the shifter with its default parameters: a 32-bit word and a 6-bit effective count. With these values the wrap at 64, the exact-width distance 32 and the oversized range 33..63 can all be reached with small count values. The directed cases sit on these boundaries for each of the three shift kinds. A long pseudo-random sweep then exercises every count class against a loop-based reference model of bit-by-bit shifting.

// File: rtl/shf_pkg.sv
package shf_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned AMT_W  = 6;

    typedef enum logic [1:0] {
        SH_LSL  = 2'b00,
        SH_LSR  = 2'b01,
        SH_ASR  = 2'b10,
        SH_HOLD = 2'b11
    } shop_e;

    typedef enum logic [1:0] {
        CC_ZERO   = 2'd0,
        CC_PART   = 2'd1,
        CC_FULL   = 2'd2,
        CC_BEYOND = 2'd3
    } cnt_cls_e;

    typedef struct packed {
        logic c;
        logic x;
        logic n;
        logic z;
        logic v;
    } ccr_t;

endpackage

// File: rtl/shf_count_class.sv
module shf_count_class
    import shf_pkg::*;
#(
    parameter int unsigned WIDTH = DATA_W,
    parameter int unsigned CNT_W = AMT_W
) (
    input  logic [CNT_W-1:0] amt_i,
    output cnt_cls_e         cls_o
);

    localparam int unsigned AMT_EXT = CNT_W + 8;

    logic [AMT_EXT-1:0] amt_ext;
    logic [AMT_EXT-1:0] width_ext;

    assign amt_ext   = AMT_EXT'(amt_i);
    assign width_ext = AMT_EXT'(WIDTH);

    always_comb begin
        if (amt_ext == '0)
            cls_o = CC_ZERO;
        else if (amt_ext < width_ext)
            cls_o = CC_PART;
        else if (amt_ext == width_ext)
            cls_o = CC_FULL;
        else
            cls_o = CC_BEYOND;
    end

endmodule

// File: rtl/shf_core.sv
module shf_core
    import shf_pkg::*;
#(
    parameter int unsigned WIDTH = DATA_W,
    parameter int unsigned CNT_W = AMT_W
) (
    input  shop_e             op_i,
    input  logic [CNT_W-1:0]  amt_i,
    input  cnt_cls_e          cls_i,
    input  logic [WIDTH-1:0]  a_i,
    input  logic              old_c_i,
    output logic [WIDTH-1:0]  res_o,
    output logic              cy_o
);

    localparam int unsigned EXT_W = WIDTH + 1;

    logic        [EXT_W-1:0] ext_l;
    logic        [EXT_W-1:0] ext_r;
    logic signed [EXT_W-1:0] seed_a;
    logic signed [EXT_W-1:0] ext_a;

    // One guard bit on the side bits leave; it catches the carry, and
    // distances past the word drain both the value and the guard bit.
    always_comb begin
        ext_l  = {1'b0, a_i} << amt_i;
        ext_r  = {a_i, 1'b0} >> amt_i;
        seed_a = {a_i, 1'b0};
        ext_a  = seed_a >>> amt_i;
    end

    always_comb begin
        res_o = a_i;
        cy_o  = old_c_i;
        if (cls_i != CC_ZERO) begin
            unique case (op_i)
                SH_LSL: begin
                    res_o = ext_l[WIDTH-1:0];
                    cy_o  = ext_l[WIDTH];
                end
                SH_LSR: begin
                    res_o = ext_r[WIDTH:1];
                    cy_o  = ext_r[0];
                end
                SH_ASR: begin
                    res_o = ext_a[WIDTH:1];
                    cy_o  = ext_a[0];
                end
                default: begin
                    res_o = a_i;
                    cy_o  = old_c_i;
                end
            endcase
        end
    end

    always_comb begin
        if (!$isunknown({op_i, amt_i, a_i, old_c_i})) begin
            AST_ZERO_KEEP: assert (cls_i != CC_ZERO || (res_o == a_i && cy_o == old_c_i)); // R2
            AST_BEYOND_DRAIN: assert (!(cls_i == CC_BEYOND && (op_i == SH_LSL || op_i == SH_LSR)) || (res_o == '0 && !cy_o)); // R6
            AST_WIDE_FILL: assert (!((cls_i == CC_FULL || cls_i == CC_BEYOND) && op_i == SH_ASR) || (res_o == {WIDTH{a_i[WIDTH-1]}} && cy_o == a_i[WIDTH-1])); // R8
        end
    end

endmodule

// File: rtl/shf_flags.sv
module shf_flags
    import shf_pkg::*;
#(
    parameter int unsigned WIDTH = DATA_W
) (
    input  logic [WIDTH-1:0] res_i,
    input  logic             cy_i,
    output ccr_t             ccr_o
);

    always_comb begin
        ccr_o.c = cy_i;
        ccr_o.x = cy_i;
        ccr_o.n = res_i[WIDTH-1];
        ccr_o.z = ~|res_i;
        ccr_o.v = 1'b0;
    end

endmodule

// File: rtl/shf_unit.sv
module shf_unit
    import shf_pkg::*;
#(
    parameter int unsigned WIDTH = DATA_W,
    parameter int unsigned CNT_W = AMT_W
) (
    input  logic [WIDTH-1:0] operand_i,
    input  logic [WIDTH-1:0] count_i,
    input  logic [1:0]       op_i,
    input  logic             c_prev_i,
    output logic [WIDTH-1:0] result_o,
    output logic             c_o,
    output logic             x_o,
    output logic             n_o,
    output logic             z_o,
    output logic             v_o
);

    logic [CNT_W-1:0] amt;
    cnt_cls_e         cls;
    shop_e            op;
    logic [WIDTH-1:0] res;
    logic             cy;
    ccr_t             ccr;

    assign amt = count_i[CNT_W-1:0];
    assign op  = shop_e'(op_i);

    shf_count_class #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_class (
        .amt_i (amt),
        .cls_o (cls)
    );

    shf_core #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_core (
        .op_i    (op),
        .amt_i   (amt),
        .cls_i   (cls),
        .a_i     (operand_i),
        .old_c_i (c_prev_i),
        .res_o   (res),
        .cy_o    (cy)
    );

    shf_flags #(.WIDTH(WIDTH)) u_flags (
        .res_i (res),
        .cy_i  (cy),
        .ccr_o (ccr)
    );

    assign result_o = res;
    assign c_o      = ccr.c;
    assign x_o      = ccr.x;
    assign n_o      = ccr.n;
    assign z_o      = ccr.z;
    assign v_o      = ccr.v;

    always_comb begin
        if (!$isunknown({operand_i, count_i, op_i, c_prev_i})) begin
            AST_HOLD_PASS: assert (op_i != 2'b11 || (result_o == operand_i && c_o == c_prev_i)); // R11
            AST_NZ_EXCL: assert (!(n_o && z_o)); // R10
            AST_V_CLEAR: assert (!v_o); // R10
        end
    end

endmodule

// File: tb/test_shf_unit.sv
module test_shf_unit;

    typedef struct {
        logic [31:0] res;
        logic        c;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] operand_i = '0;
    logic [31:0] count_i   = '0;
    logic [1:0]  op_i      = '0;
    logic        c_prev_i  = 1'b0;
    logic [31:0] result_o;
    logic        c_o, x_o, n_o, z_o, v_o;

    int   total = 0;
    int   bad   = 0;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    shf_unit i_shf_unit (
        .operand_i (operand_i),
        .count_i   (count_i),
        .op_i      (op_i),
        .c_prev_i  (c_prev_i),
        .result_o  (result_o),
        .c_o       (c_o),
        .x_o       (x_o),
        .n_o       (n_o),
        .z_o       (z_o),
        .v_o       (v_o)
    );

    function automatic logic [32:0] model(logic [31:0] a, logic [31:0] cnt,
                                          logic [1:0] op, logic oc);
        logic [31:0] r = a;
        logic        c = oc;
        int          n = int'(cnt[5:0]);
        if (op != 2'b11) begin
            for (int i = 0; i < n; i++) begin
                case (op)
                    2'b00:   begin c = r[31]; r = {r[30:0], 1'b0}; end
                    2'b01:   begin c = r[0];  r = {1'b0, r[31:1]}; end
                    default: begin c = r[0];  r = {r[31], r[31:1]}; end
                endcase
            end
        end
        return {c, r};
    endfunction

    task automatic drive(input logic [31:0] a, input logic [31:0] cnt,
                         input logic [1:0] op, input logic oc, input string tag);
        exp_t        e;
        logic [32:0] m;
        @(posedge clk);
        #1;
        operand_i = a;
        count_i   = cnt;
        op_i      = op;
        c_prev_i  = oc;
        m     = model(a, cnt, op, oc);
        e.res = m[31:0];
        e.c   = m[32];
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            total++;
            if (result_o !== e.res || c_o !== e.c || n_o !== e.res[31] ||
                z_o !== (e.res == 0) || v_o !== 1'b0) begin
                bad++;
                $display("FAIL %s (R10 flags): res=%h c=%b n=%b z=%b v=%b expected res=%h c=%b n=%b z=%b v=0",
                         e.tag, result_o, c_o, n_o, z_o, v_o, e.res, e.c, e.res[31], e.res == 0);
            end
            total++;
            if (x_o !== e.c) begin
                bad++;
                $display("FAIL R9 (%s): x=%b expected %b", e.tag, x_o, e.c);
            end
        end
    end

    task automatic run_all();
        logic [31:0] lfsr = 32'hACE1_2469;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        drive(32'h0, 32'h0, 2'b00, 1'b0, "R2 reset-like all-zero");
        drive(32'h0000_00A5, 32'd0, 2'b00, 1'b1, "R2 lsl zero count");
        drive(32'h8000_0001, 32'd0, 2'b10, 1'b0, "R2 asr zero count");
        drive(32'h1234_5678, 32'd68, 2'b00, 1'b0, "R1 count 68 as 4");
        drive(32'hFFFF_0000, 32'd64, 2'b01, 1'b1, "R1 count 64 as 0");
        drive(32'h8000_0001, 32'd1, 2'b00, 1'b0, "R3 lsl 1");
        drive(32'h0000_0003, 32'd31, 2'b00, 1'b0, "R3 lsl 31");
        drive(32'h0000_0001, 32'd32, 2'b00, 1'b0, "R4 lsl 32");
        drive(32'hFFFF_FFFF, 32'd33, 2'b00, 1'b1, "R4 lsl 33");
        drive(32'h0000_0003, 32'd1, 2'b01, 1'b0, "R5 lsr 1");
        drive(32'h8000_0000, 32'd31, 2'b01, 1'b0, "R5 lsr 31");
        drive(32'h8000_0000, 32'd32, 2'b01, 1'b0, "R6 lsr 32");
        drive(32'hFFFF_FFFF, 32'd50, 2'b01, 1'b1, "R6 lsr 50");
        drive(32'h8000_0018, 32'd4, 2'b10, 1'b0, "R7 asr 4 negative");
        drive(32'h7FFF_FFFF, 32'd1, 2'b10, 1'b0, "R7 asr 1 positive");
        drive(32'h8000_0000, 32'd32, 2'b10, 1'b0, "R8 asr 32");
        drive(32'h1234_5678, 32'd63, 2'b10, 1'b1, "R8 asr 63 positive");
        drive(32'hF000_0000, 32'd40, 2'b10, 1'b0, "R8 asr 40 negative");
        drive(32'h0000_0001, 32'd1, 2'b01, 1'b0, "R10 zero result");
        drive(32'hDEAD_BEEF, 32'd5, 2'b11, 1'b1, "R11 pass code");
        drive(32'h0000_0000, 32'd9, 2'b11, 1'b0, "R11 pass zero");
        for (int k = 0; k < 400; k++) begin
            logic [31:0] a;
            logic [31:0] cnt;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            a    = lfsr;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            cnt  = lfsr;
            drive(a, cnt, lfsr[7:6], lfsr[9], "R9 sweep");
        end
        @(posedge clk);
        @(posedge clk);
    endtask

    initial begin
        bit hung = 1'b0;
        fork
            run_all();
            begin
                repeat (20000) @(posedge clk);
                hung = 1'b1;
            end
        join_any
        disable fork;
        if (hung) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule